// File: doc/BRIEF.md
# UART with Programmable Oversampling

This block is a serial transmitter and receiver behind a small word-addressed register bus. Every register is 32 bits wide on the bus, and only the low byte carries meaning. Characters are framed as one low start bit, eight data bits sent least significant bit first, and one high stop bit. There is no parity.

The bit period is set by a 16-bit divisor and a sampling-mode register. The divisor sets how many input clocks make one sub-bit tick. The mode sets how many ticks make one bit: sixteen, four, or a software-chosen count. In the software-chosen mode, the tick at which the receiver samples each bit is also set by software.

Software sets the divisor through a latch window that is opened by line-control bit 7. It sends a byte by writing the transmit holding register while the line status reports that register empty. It polls data-ready and then reads the received byte.

Top module: `uart_os_top`

## Requirements
- R1: After reset, line status (word 5) reads 0x20, interrupt enable (word 1) reads 0, sampling mode (word 9) reads 0, sample count (word 10) reads 0, sample point (word 11) reads 0xFF, and `txd` is high.
- R2: While line-control (word 3) bit 7 is 1, word 0 reads and writes the low divisor byte and word 1 the high divisor byte. While that bit is 0, word 0 is the receive/transmit data register and word 1 is interrupt enable. Line control reads back what was written.
- R3: Interrupt enable stores and reads back an 8-bit value. Writing 0 clears it.
- R4: With sampling mode 0 or 1, one bit lasts 16 × divisor clocks.
- R5: With sampling mode 2, one bit lasts 4 × divisor clocks.
- R6: With sampling mode 3, one bit lasts divisor × (sample count + 1) clocks, and the receiver samples each bit at the sub-bit tick held in sample point. In modes 0 and 1 it samples at tick 7; in mode 2 it samples at tick 1.
- R7: The transmitted frame is a 0 start bit, then the 8 data bits LSB first, then a 1 stop bit. `txd` is high whenever the transmitter is idle.
- R8: Line-status bit 5 (transmit empty) is 1 when the transmitter is idle. It drops in the cycle after an accepted data write and returns to 1 when the stop bit ends. A data write while the bit is 0 is ignored.
- R9: Line-status bit 0 (data ready) is set when a received byte is stored. It is cleared by a read of the receive data register (word 0, latch window closed).
- R10: After a falling edge on `rxd`, the start bit is checked again at the sample tick. If the line is high at that tick, the start is discarded and no byte is stored.
- R11: If the stop bit is sampled low, the byte is still stored, data ready is set, and line-status bit 3 (framing error) is set. The receive-data read clears bit 3.
- R12: A divisor of 0 keeps both directions idle. Data writes are ignored, transmit empty stays 1, `txd` stays high, and no byte is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWe | input | 1 | Register write strobe |
| busRe | input | 1 | Register read strobe; its side effects apply at the clock edge |
| busAddr | input | 4 | Word address |
| busWdata | input | 32 | Write data; only bits 7:0 are used |
| busRdata | output | 32 | Read data, combinational from the address; bits 31:8 are zero |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |

## Verification
The assertions assume that `busWe` and `busRe` are never both high in the same cycle. They also assume that `rxd` changes only at whole-clock boundaries, so that after reset the data-ready and transmit-empty flags move only through the bus strobes and the serial line. The stimulus drives every bus access and every serial bit at the falling clock edge, performs one access at a time, and holds each `rxd` level for an exact number of bit periods. In mode 3 the bench keeps sample point below sample count + 1; a sample point at or above that value would never be reached.

// File: rtl/uart_os_pkg.sv
package uart_os_pkg;
  localparam int DIV_W  = 16;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_DATA  = 4'd0;
  localparam logic [ADDR_W-1:0] A_IEN   = 4'd1;
  localparam logic [ADDR_W-1:0] A_LINE  = 4'd3;
  localparam logic [ADDR_W-1:0] A_STAT  = 4'd5;
  localparam logic [ADDR_W-1:0] A_MODE  = 4'd9;
  localparam logic [ADDR_W-1:0] A_SCNT  = 4'd10;
  localparam logic [ADDR_W-1:0] A_SPNT  = 4'd11;

  typedef struct packed {
    logic txLoad;
    logic rbrRead;
  } ctrl_strobe_t;

  typedef struct packed {
    logic [DIV_W-1:0]  divisor;
    logic [BYTE_W-1:0] ticksM1;
    logic [BYTE_W-1:0] samplePt;
  } timing_cfg_t;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;
endpackage

// File: rtl/uart_os_bit_timer.sv
module uart_os_bit_timer #(
  parameter int DIV_W = 16,
  parameter int SUB_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic [DIV_W-1:0] divisor,
  input  logic [SUB_W-1:0] ticksM1,
  input  logic [SUB_W-1:0] samplePt,
  output logic             sampleHit,
  output logic             bitEnd
);
  logic [DIV_W-1:0] preCnt;
  logic [SUB_W-1:0] subIdx;
  logic tickPulse;

  assign tickPulse = run && (divisor != '0) && (preCnt == divisor - DIV_W'(1));
  assign sampleHit = tickPulse && (subIdx == samplePt);
  assign bitEnd    = tickPulse && (subIdx == ticksM1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      subIdx <= '0;
    end else if (!run || divisor == '0) begin
      preCnt <= '0;
      subIdx <= '0;
    end else if (tickPulse) begin
      preCnt <= '0;
      subIdx <= (subIdx == ticksM1) ? '0 : subIdx + SUB_W'(1);
    end else begin
      preCnt <= preCnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/uart_os_ctrl.sv
module uart_os_ctrl
  import uart_os_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWe,
  input  logic               busRe,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [BYTE_W-1:0]  wByte,
  output logic [BYTE_W-1:0]  rByte,
  input  logic               dr,
  input  logic               fe,
  input  logic               thre,
  input  logic [BYTE_W-1:0]  rxByte,
  output ctrl_strobe_t       strb,
  output timing_cfg_t        cfg
);
  logic [BYTE_W-1:0] lineCtl, dlLo, dlHi, ienReg, sCnt, sPnt;
  logic [1:0] modeReg;
  logic dlab;

  assign dlab = lineCtl[7];
  assign strb.txLoad  = busWe && busAddr == A_DATA && !dlab;
  assign strb.rbrRead = busRe && busAddr == A_DATA && !dlab;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineCtl <= '0;
      dlLo    <= '0;
      dlHi    <= '0;
      ienReg  <= '0;
      modeReg <= '0;
      sCnt    <= '0;
      sPnt    <= 8'hFF;
    end else if (busWe) begin
      case (busAddr)
        A_DATA:  if (dlab) dlLo <= wByte;
        A_IEN:   if (dlab) dlHi <= wByte; else ienReg <= wByte;
        A_LINE:  lineCtl <= wByte;
        A_MODE:  modeReg <= wByte[1:0];
        A_SCNT:  sCnt <= wByte;
        A_SPNT:  sPnt <= wByte;
        default: ;
      endcase
    end
  end

  always_comb begin
    cfg.divisor = {dlHi, dlLo};
    case (modeReg)
      2'd3: begin cfg.ticksM1 = sCnt;  cfg.samplePt = sPnt;  end
      2'd2: begin cfg.ticksM1 = 8'd3;  cfg.samplePt = 8'd1;  end
      default: begin cfg.ticksM1 = 8'd15; cfg.samplePt = 8'd7; end
    endcase
  end

  always_comb begin
    case (busAddr)
      A_DATA:  rByte = dlab ? dlLo : rxByte;
      A_IEN:   rByte = dlab ? dlHi : ienReg;
      A_LINE:  rByte = lineCtl;
      A_STAT:  rByte = {2'b00, thre, 1'b0, fe, 2'b00, dr};
      A_MODE:  rByte = {6'd0, modeReg};
      A_SCNT:  rByte = sCnt;
      A_SPNT:  rByte = sPnt;
      default: rByte = '0;
    endcase
  end
endmodule

// File: rtl/uart_os_datapath.sv
module uart_os_datapath
  import uart_os_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strb,
  input  timing_cfg_t       cfg,
  input  logic [BYTE_W-1:0] txData,
  input  logic              rxd,
  output logic              txd,
  output logic              thre,
  output logic              dr,
  output logic              fe,
  output logic [BYTE_W-1:0] rxByte
);
  localparam int FRAME_W = BYTE_W + 2;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic divOk;
  assign divOk = cfg.divisor != '0;

  // transmit side
  logic [FRAME_W-1:0] txFrame;
  logic [CNT_W-1:0]   txCnt;
  logic txBusy, txHitUnused, txBitEnd;

  uart_os_bit_timer #(.DIV_W(DIV_W), .SUB_W(BYTE_W)) u_txTimer (
    .clk(clk), .rstN(rstN), .run(txBusy), .divisor(cfg.divisor),
    .ticksM1(cfg.ticksM1), .samplePt(cfg.samplePt),
    .sampleHit(txHitUnused), .bitEnd(txBitEnd));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txFrame <= '1;
      txCnt   <= '0;
      txBusy  <= 1'b0;
    end else if (!txBusy) begin
      if (strb.txLoad && divOk) begin
        txFrame <= {1'b1, txData, 1'b0};
        txCnt   <= '0;
        txBusy  <= 1'b1;
      end
    end else if (txBitEnd) begin
      txFrame <= {1'b1, txFrame[FRAME_W-1:1]};
      txCnt   <= txCnt + CNT_W'(1);
      if (txCnt == CNT_W'(FRAME_W - 1)) txBusy <= 1'b0;
    end
  end

  assign txd  = txBusy ? txFrame[0] : 1'b1;
  assign thre = !txBusy;

  // receive side
  rx_state_t rxState;
  logic rxMeta, rxSync, rxPrev, rxHit, rxEndUnused;
  logic [BYTE_W-1:0] rxShift;
  logic [CNT_W-1:0]  rxCnt;

  uart_os_bit_timer #(.DIV_W(DIV_W), .SUB_W(BYTE_W)) u_rxTimer (
    .clk(clk), .rstN(rstN), .run(rxState != RX_IDLE), .divisor(cfg.divisor),
    .ticksM1(cfg.ticksM1), .samplePt(cfg.samplePt),
    .sampleHit(rxHit), .bitEnd(rxEndUnused));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta  <= 1'b1;
      rxSync  <= 1'b1;
      rxPrev  <= 1'b1;
      rxState <= RX_IDLE;
      rxShift <= '0;
      rxCnt   <= '0;
      rxByte  <= '0;
      dr      <= 1'b0;
      fe      <= 1'b0;
    end else begin
      rxMeta <= rxd;
      rxSync <= rxMeta;
      rxPrev <= rxSync;
      if (strb.rbrRead) begin
        dr <= 1'b0;
        fe <= 1'b0;
      end
      case (rxState)
        RX_IDLE:  if (divOk && rxPrev && !rxSync) rxState <= RX_START;
        RX_START: if (rxHit) begin
          rxState <= rxSync ? RX_IDLE : RX_DATA;
          rxCnt   <= '0;
        end
        RX_DATA:  if (rxHit) begin
          rxShift <= {rxSync, rxShift[BYTE_W-1:1]};
          rxCnt   <= rxCnt + CNT_W'(1);
          if (rxCnt == CNT_W'(BYTE_W - 1)) rxState <= RX_STOP;
        end
        default:  if (rxHit) begin
          rxByte  <= rxShift;
          dr      <= 1'b1;
          fe      <= !rxSync;
          rxState <= RX_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/uart_os_top.sv
module uart_os_top
  import uart_os_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWe,
  input  logic        busRe,
  input  logic [3:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  input  logic        rxd,
  output logic        txd
);
  ctrl_strobe_t strb;
  timing_cfg_t  cfg;
  logic dr, fe, thre;
  logic [BYTE_W-1:0] rxByte, rByte;
  logic unusedHighBits;

  assign unusedHighBits = ^busWdata[31:BYTE_W];
  assign busRdata = {{(32-BYTE_W){1'b0}}, rByte};

  uart_os_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe), .busAddr(busAddr),
    .wByte(busWdata[BYTE_W-1:0]), .rByte(rByte), .dr(dr), .fe(fe),
    .thre(thre), .rxByte(rxByte), .strb(strb), .cfg(cfg));

  uart_os_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfg(cfg),
    .txData(busWdata[BYTE_W-1:0]), .rxd(rxd), .txd(txd), .thre(thre),
    .dr(dr), .fe(fe), .rxByte(rxByte));
endmodule

// File: rtl/uart_os_checker.sv
module uart_os_checker (
  input logic clk,
  input logic rstN,
  input logic txLoad,
  input logic rbrRead,
  input logic divZero,
  input logic thre,
  input logic txd,
  input logic dr,
  input logic fe
);
  // R8: an accepted data write makes the transmitter busy
  a_r8_busy_after_load: assert property (@(posedge clk) disable iff (!rstN)
    (txLoad && thre && !divZero) |=> !thre);

  // R7: the line stays high while idle
  a_r7_idle_line_high: assert property (@(posedge clk) disable iff (!rstN)
    thre |-> txd);

  // R12: a zero divisor keeps the transmitter idle
  a_r12_zero_div_idle: assert property (@(posedge clk) disable iff (!rstN)
    (divZero && thre) |=> thre);

  // R9: data ready only falls after a receive-data read
  a_r9_dr_falls_on_read: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dr) |-> $past(rbrRead));

  // R11: framing error only accompanies a stored byte
  a_r11_fe_with_dr: assert property (@(posedge clk) disable iff (!rstN)
    fe |-> dr);
endmodule

bind uart_os_top uart_os_checker u_chk (
  .clk(clk), .rstN(rstN), .txLoad(strb.txLoad), .rbrRead(strb.rbrRead),
  .divZero(cfg.divisor == 16'd0), .thre(thre), .txd(txd), .dr(dr), .fe(fe));

// File: tb/uart_os_top_tb.sv
`timescale 1ns/1ps
module uart_os_top_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWe = 1'b0, busRe = 1'b0;
  logic [3:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic rxd = 1'b1;
  logic txd;

  int checks = 0;
  int fails = 0;
  int bitPer = 32;
  int txFrames = 0;
  logic [7:0] expQ[$];
  logic [31:0] rd;

  always #2.5 clk = ~clk;

  uart_os_top u_dut (.clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .rxd(rxd), .txd(txd));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = {24'hABCDEF, d}; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rdReg(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    busAddr = a; busRe = 1'b1;
    #1 v = busRdata;
    @(negedge clk);
    busRe = 1'b0;
  endtask

  task automatic setDiv(input logic [15:0] d);
    wr(4'd3, 8'h83);
    wr(4'd0, d[7:0]);
    wr(4'd1, d[15:8]);
    wr(4'd3, 8'h03);
  endtask

  task automatic driveRx(input logic [7:0] b, input int per, input logic stopBit);
    @(negedge clk);
    rxd = 1'b0;
    repeat (per) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (per) @(negedge clk);
    end
    rxd = stopBit;
    repeat (per) @(negedge clk);
    rxd = 1'b1;
    repeat (per) @(negedge clk);
  endtask

  task automatic sendTx(input logic [7:0] b);
    expQ.push_back(b);
    wr(4'd0, b);
  endtask

  task automatic finishRun;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // monitor: decode txd and compare against the scoreboard queue (R7)
  initial begin
    logic [7:0] got;
    logic [7:0] exp;
    forever begin
      @(negedge clk);
      if (rstN && txd == 1'b0) begin
        repeat (bitPer / 2) @(negedge clk);
        chk("R7 start bit", {31'd0, txd}, 32'd0);
        for (int i = 0; i < 8; i++) begin
          repeat (bitPer) @(negedge clk);
          got[i] = txd;
        end
        repeat (bitPer) @(negedge clk);
        chk("R7 stop bit", {31'd0, txd}, 32'd1);
        txFrames++;
        if (expQ.size() == 0) chk("R8 unexpected frame", {24'd0, got}, 32'hFFFF_FFFF);
        else begin
          exp = expQ.pop_front();
          chk("R7 tx byte", {24'd0, got}, {24'd0, exp});
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    rdReg(4'd5, rd); chk("R1 status", rd, 32'h20);
    rdReg(4'd1, rd); chk("R1 ien", rd, 32'h0);
    rdReg(4'd9, rd); chk("R1 mode", rd, 32'h0);
    rdReg(4'd10, rd); chk("R1 scount", rd, 32'h0);
    rdReg(4'd11, rd); chk("R1 spoint", rd, 32'hFF);
    chk("R1 txd", {31'd0, txd}, 32'd1);

    // R2 latch window and R3 interrupt enable
    wr(4'd1, 8'h05);
    rdReg(4'd1, rd); chk("R3 ien readback", rd, 32'h05);
    wr(4'd3, 8'h83);
    wr(4'd0, 8'h02); wr(4'd1, 8'h00);
    rdReg(4'd0, rd); chk("R2 low divisor", rd, 32'h02);
    rdReg(4'd1, rd); chk("R2 high divisor", rd, 32'h00);
    rdReg(4'd3, rd); chk("R2 line ctl", rd, 32'h83);
    wr(4'd3, 8'h03);
    rdReg(4'd1, rd); chk("R2 ien after close", rd, 32'h05);
    rdReg(4'd0, rd); chk("R2 rx data after close", rd, 32'h00);
    wr(4'd1, 8'h00);
    rdReg(4'd1, rd); chk("R3 ien cleared", rd, 32'h00);

    // R4 mode 1, divisor 2: 32 clocks per bit; R8 busy write ignored
    wr(4'd9, 8'd1);
    bitPer = 32;
    sendTx(8'hA5);
    rdReg(4'd5, rd); chk("R8 busy status", rd & 32'h20, 32'h0);
    wr(4'd0, 8'hFF);
    repeat (10 * 32 + 20) @(negedge clk);
    rdReg(4'd5, rd); chk("R8 idle again", rd, 32'h20);
    chk("R4 frames", txFrames, 1);

    // R5 mode 2, divisor 3: 12 clocks per bit
    wr(4'd9, 8'd2); setDiv(16'd3);
    bitPer = 12;
    sendTx(8'h3C);
    repeat (10 * 12 + 20) @(negedge clk);
    chk("R5 frames", txFrames, 2);

    // R6 mode 3, divisor 2, 10 ticks: 20 clocks per bit
    wr(4'd9, 8'd3); wr(4'd10, 8'd9); wr(4'd11, 8'd4); setDiv(16'd2);
    rdReg(4'd10, rd); chk("R6 scount", rd, 32'd9);
    rdReg(4'd11, rd); chk("R6 spoint", rd, 32'd4);
    bitPer = 20;
    sendTx(8'h81);
    repeat (10 * 20 + 20) @(negedge clk);
    chk("R6 frames", txFrames, 3);
    driveRx(8'hC3, 20, 1'b1);
    rdReg(4'd5, rd); chk("R6 rx status", rd, 32'h21);
    rdReg(4'd0, rd); chk("R6 rx byte", rd, 32'hC3);

    // R9 mode 0 receive
    wr(4'd9, 8'd0);
    driveRx(8'h5A, 32, 1'b1);
    rdReg(4'd5, rd); chk("R9 data ready", rd, 32'h21);
    rdReg(4'd0, rd); chk("R9 rx byte", rd, 32'h5A);
    rdReg(4'd5, rd); chk("R9 ready cleared", rd, 32'h20);

    // R10 short low pulse discarded
    @(negedge clk); rxd = 1'b0;
    repeat (4) @(negedge clk); rxd = 1'b1;
    repeat (400) @(negedge clk);
    rdReg(4'd5, rd); chk("R10 glitch ignored", rd, 32'h20);
    driveRx(8'h96, 32, 1'b1);
    rdReg(4'd0, rd); chk("R10 byte after glitch", rd, 32'h96);

    // R11 framing error
    driveRx(8'h44, 32, 1'b0);
    rdReg(4'd5, rd); chk("R11 framing flag", rd, 32'h29);
    rdReg(4'd0, rd); chk("R11 byte kept", rd, 32'h44);
    rdReg(4'd5, rd); chk("R11 flags cleared", rd, 32'h20);

    // R12 zero divisor holds idle
    setDiv(16'd0);
    wr(4'd0, 8'h77);
    repeat (50) @(negedge clk);
    rdReg(4'd5, rd); chk("R12 status idle", rd, 32'h20);
    chk("R12 txd high", {31'd0, txd}, 32'd1);
    driveRx(8'h33, 32, 1'b1);
    rdReg(4'd5, rd); chk("R12 nothing received", rd, 32'h20);
    chk("R12 frames", txFrames, 3);
    chk("R8 queue empty", expQ.size(), 0);
    finishRun();
  end
endmodule